// File: doc/BRIEF.md
# Dual-Bank Input Color Matrix

This block converts a stream of pixels, one per clock, from three 12-bit input components to red, green and blue. The components may be luma and two chroma values, or RGB. Each output channel is an affine function of the inputs: three signed products plus a signed offset. The result is rounded to nearest and clamped to the 12-bit output range.

The block holds two complete coefficient sets. Each set is a 3x4 matrix. Software writes both sets through a simple 32-bit write port and picks one of them, or a pure pass-through, with a 2-bit mode field. The pipeline delay is fixed in every mode. A new coefficient set can therefore be loaded into the idle bank while the other bank is in use, and the switch takes effect on an exact pixel boundary.

Top module: `cmx_color_matrix`

## Requirements
- R1: After reset, `out_valid` is 0, every coefficient is 0 and the mode is 0 (pass-through).
- R2: In mode 0, each output equals the input component with the same index (red=`in_c0`, green=`in_c1`, blue=`in_c2`), unchanged.
- R3: Mode 1 applies bank A. Mode 2 applies bank B. Mode 3 behaves exactly like mode 0.
- R4: Matrix row 0 produces red, row 1 green and row 2 blue. In each row, columns 0, 1 and 2 multiply `in_c0`, `in_c1` and `in_c2`, and column 3 is the offset.
- R5: Address map. Addresses 0..5 hold bank A and addresses 8..13 hold bank B. Address 15 holds the mode in `cfg_wdata[1:0]`. For pair index p (the address bits [2:0]), the row is p/2. Bits [15:0] hold column 2*(p%2) and bits [31:16] hold the next column.
- R6: Coefficients are 16-bit two's complement with 13 fraction bits. The value 0x2000 is a gain of 1.0, so the identity matrix returns the input unchanged.
- R7: The offset is a signed integer in output LSB units. It is scaled by 2^13 before it is added to the products.
- R8: The sum is rounded to nearest by adding 2^12 and then shifting right arithmetically by 13. Ties therefore round upward.
- R9: A rounded result below 0 gives 0, and a rounded result above 4095 gives 4095.
- R10: `out_valid` follows `in_valid` exactly 3 cycles later in every mode, with bubbles and order kept.
- R11: A write takes effect for pixels presented in the cycle after the write. A pixel presented in the same cycle as the write uses the old coefficients and the old mode.
- R12: Writes to addresses 6, 7 and 14 change no coefficient and not the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration registers |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_c0 | input | 12 | Input component 0 (Y or R) |
| in_c1 | input | 12 | Input component 1 (Cb or G) |
| in_c2 | input | 12 | Input component 2 (Cr or B) |
| out_valid | output | 1 | Output pixel valid |
| out_red | output | 12 | Red result |
| out_green | output | 12 | Green result |
| out_blue | output | 12 | Blue result |

## Verification
The assertions run on every cycle and check the following:
- the 3-cycle valid delay in both directions;
- the exact copy of the inputs in the two pass-through modes;
- the low and high clamps whenever the sum crosses a limit;
- the lanes of a pair write and the mode write;
- that writes to unmapped addresses change nothing.

Some behaviour can only be shown by the bench scenarios, because it needs a reference value:
- the arithmetic of real matrices, with signed cross terms and offsets;
- which bank is active in each mode;
- rounding at exact half values;
- the same-cycle ordering of a write against a pixel, which the bench shows by comparing the pixel before and the pixel after a write.

// File: rtl/cmx_pkg.sv
package cmx_pkg;
  localparam int PIX_W   = 12;
  localparam int COEF_W  = 16;
  localparam int FRAC_W  = 13;
  localparam int ACC_W   = 32;
  localparam int ROWS    = 3;
  localparam int COLS    = 4;
  localparam int BANKS   = 2;
  localparam int ADDR_W  = 4;

  typedef enum logic [1:0] {
    MODE_PASS     = 2'd0,
    MODE_BANK_A   = 2'd1,
    MODE_BANK_B   = 2'd2,
    MODE_PASS_ALT = 2'd3
  } cmx_mode_e;
endpackage

// File: rtl/cmx_coef_regs.sv
module cmx_coef_regs
  import cmx_pkg::*;
#(
  parameter int P_COEF_W = COEF_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_ROWS   = ROWS,
  parameter int P_COLS   = COLS,
  parameter int P_BANKS  = BANKS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [P_ADDR_W-1:0] cfg_addr,
  input  logic [2*P_COEF_W-1:0] cfg_wdata,
  output logic [P_BANKS-1:0][P_ROWS-1:0][P_COLS-1:0][P_COEF_W-1:0] bank_q,
  output logic [1:0]          mode_q
);
  localparam int PAIRS     = P_ROWS * P_COLS / 2;
  localparam int PAIR_W    = P_ADDR_W - 1;
  localparam int ROW_W     = $clog2(P_ROWS);
  localparam int COL_W     = $clog2(P_COLS);
  localparam int BSEL_W    = (P_BANKS > 1) ? $clog2(P_BANKS) : 1;
  localparam logic [P_ADDR_W-1:0] MODE_ADDR = '1;

  logic [PAIR_W-1:0] pair;
  logic [BSEL_W-1:0] bsel;
  logic [ROW_W-1:0]  prow;
  logic [COL_W-1:0]  pcol_lo;
  logic [COL_W-1:0]  pcol_hi;
  logic              pair_ok;
  logic              mode_hit;

  always_comb begin
    pair     = cfg_addr[PAIR_W-1:0];
    bsel     = BSEL_W'(cfg_addr[P_ADDR_W-1]);
    prow     = ROW_W'(pair >> 1);
    pcol_lo  = COL_W'({pair[0], 1'b0});
    pcol_hi  = pcol_lo | COL_W'(1);
    mode_hit = (cfg_addr == MODE_ADDR);
    pair_ok  = !mode_hit && (int'(pair) < PAIRS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_PASS;
      bank_q <= '0;
    end else if (cfg_we) begin
      if (mode_hit) begin
        mode_q <= cfg_wdata[1:0];
      end else if (pair_ok) begin
        bank_q[bsel][prow][pcol_lo] <= cfg_wdata[P_COEF_W-1:0];
        bank_q[bsel][prow][pcol_hi] <= cfg_wdata[2*P_COEF_W-1:P_COEF_W];
      end
    end
  end

  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && mode_hit) |=> (mode_q == $past(cfg_wdata[1:0]))); // R5

  AST_PAIR_LANES: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && pair_ok) |=>
      (bank_q[$past(bsel)][$past(prow)][$past(pcol_lo)] == $past(cfg_wdata[P_COEF_W-1:0]) &&
       bank_q[$past(bsel)][$past(prow)][$past(pcol_hi)] == $past(cfg_wdata[2*P_COEF_W-1:P_COEF_W]))); // R5

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !mode_hit && !pair_ok) |=> ($stable(bank_q) && $stable(mode_q))); // R12
endmodule

// File: rtl/cmx_row_pipe.sv
module cmx_row_pipe
  import cmx_pkg::*;
#(
  parameter int P_PIX_W  = PIX_W,
  parameter int P_COEF_W = COEF_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_ACC_W  = ACC_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 bypass,
  input  logic [P_PIX_W-1:0]   byp_pix,
  input  logic [P_PIX_W-1:0]   x0,
  input  logic [P_PIX_W-1:0]   x1,
  input  logic [P_PIX_W-1:0]   x2,
  input  logic [3:0][P_COEF_W-1:0] coef,
  output logic                 out_valid,
  output logic [P_PIX_W-1:0]   out_pix
);
  localparam int PROD_W  = P_PIX_W + 1 + P_COEF_W;
  localparam int PIX_MAX = (1 << P_PIX_W) - 1;
  localparam logic signed [P_ACC_W-1:0] HALF = P_ACC_W'(1) <<< (P_FRAC_W - 1);

  logic signed [P_PIX_W:0]  xs [3];
  logic signed [PROD_W-1:0] p1 [3];
  logic signed [P_ACC_W-1:0] off1, sum2, rnd, q;
  logic                     v1, v2, byp1, byp2;
  logic [P_PIX_W-1:0]       bpix1, bpix2;

  always_comb begin
    xs[0] = signed'({1'b0, x0});
    xs[1] = signed'({1'b0, x1});
    xs[2] = signed'({1'b0, x2});
  end

  // stage 1: products and scaled offset, coefficients sampled here only (R11)
  generate
    for (genvar k = 0; k < 3; k++) begin : g_mul
      always_ff @(posedge clk) begin
        p1[k] <= xs[k] * signed'(coef[k]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    off1  <= signed'({{(P_ACC_W-P_COEF_W){coef[3][P_COEF_W-1]}}, coef[3]} <<< P_FRAC_W);
    byp1  <= bypass;
    bpix1 <= byp_pix;
  end

  // stage 2: sum
  always_ff @(posedge clk) begin
    sum2  <= P_ACC_W'(p1[0]) + P_ACC_W'(p1[1]) + P_ACC_W'(p1[2]) + off1;
    byp2  <= byp1;
    bpix2 <= bpix1;
  end

  // stage 3: round to nearest, clamp
  always_comb begin
    rnd = sum2 + HALF;
    q   = rnd >>> P_FRAC_W;
  end

  always_ff @(posedge clk) begin
    if (byp2)           out_pix <= bpix2;
    else if (q < 0)     out_pix <= '0;
    else if (q > PIX_MAX) out_pix <= P_PIX_W'(PIX_MAX);
    else                out_pix <= q[P_PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (rst)
    (v2 && !byp2 && sum2 < -HALF) |=> (out_pix == '0)); // R9

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (v2 && !byp2 && sum2 >= (P_ACC_W'(PIX_MAX + 1) <<< P_FRAC_W) - HALF)
      |=> (out_pix == P_PIX_W'(PIX_MAX))); // R9
endmodule

// File: rtl/cmx_color_matrix.sv
module cmx_color_matrix
  import cmx_pkg::*;
#(
  parameter int P_PIX_W  = PIX_W,
  parameter int P_COEF_W = COEF_W,
  parameter int P_FRAC_W = FRAC_W,
  parameter int P_ACC_W  = ACC_W,
  parameter int P_ADDR_W = ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [P_ADDR_W-1:0]   cfg_addr,
  input  logic [2*P_COEF_W-1:0] cfg_wdata,
  input  logic                  in_valid,
  input  logic [P_PIX_W-1:0]    in_c0,
  input  logic [P_PIX_W-1:0]    in_c1,
  input  logic [P_PIX_W-1:0]    in_c2,
  output logic                  out_valid,
  output logic [P_PIX_W-1:0]    out_red,
  output logic [P_PIX_W-1:0]    out_green,
  output logic [P_PIX_W-1:0]    out_blue
);
  localparam int NCH = ROWS;

  logic [BANKS-1:0][ROWS-1:0][COLS-1:0][P_COEF_W-1:0] bank_q;
  logic [ROWS-1:0][COLS-1:0][P_COEF_W-1:0] act_coef;
  logic [1:0]          mode_q;
  logic                bypass;
  logic [P_PIX_W-1:0]  in_pix  [NCH];
  logic [P_PIX_W-1:0]  row_pix [NCH];
  logic [NCH-1:0]      row_vld;

  cmx_coef_regs #(
    .P_COEF_W(P_COEF_W), .P_ADDR_W(P_ADDR_W),
    .P_ROWS(ROWS), .P_COLS(COLS), .P_BANKS(BANKS)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bank_q(bank_q), .mode_q(mode_q)
  );

  always_comb begin
    bypass    = (mode_q != MODE_BANK_A) && (mode_q != MODE_BANK_B);
    act_coef  = (mode_q == MODE_BANK_B) ? bank_q[1] : bank_q[0];
    in_pix[0] = in_c0;
    in_pix[1] = in_c1;
    in_pix[2] = in_c2;
  end

  generate
    for (genvar r = 0; r < NCH; r++) begin : g_row
      cmx_row_pipe #(
        .P_PIX_W(P_PIX_W), .P_COEF_W(P_COEF_W),
        .P_FRAC_W(P_FRAC_W), .P_ACC_W(P_ACC_W)
      ) u_row (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bypass(bypass),
        .byp_pix(in_pix[r]), .x0(in_c0), .x1(in_c1), .x2(in_c2),
        .coef(act_coef[r]), .out_valid(row_vld[r]), .out_pix(row_pix[r])
      );
    end
  endgenerate

  always_comb begin
    out_valid = &row_vld;
    out_red   = row_pix[0];
    out_green = row_pix[1];
    out_blue  = row_pix[2];
  end

  AST_LAT_FWD: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid); // R10

  AST_LAT_BACK: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3)); // R10

  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && bypass) |-> ##3 (out_red == $past(in_c0, 3) &&
                                  out_green == $past(in_c1, 3) &&
                                  out_blue == $past(in_c2, 3))); // R2
endmodule

// File: tb/cmx_color_matrix_test.sv
module cmx_color_matrix_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic        out_valid;
  logic [11:0] out_red, out_green, out_blue;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic signed [15:0] sh [2][3][4];
  int smode = 0;

  logic [35:0] q_exp [$];
  int          q_cyc [$];
  string       q_tag [$];

  cmx_color_matrix uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_c0(in_c0),
    .in_c1(in_c1), .in_c2(in_c2), .out_valid(out_valid),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int row, int a, int b, int c);
    longint s;
    longint q;
    int x [3];
    x[0] = a; x[1] = b; x[2] = c;
    if (smode != 1 && smode != 2) return x[row];
    s = longint'(sh[smode-1][row][0]) * a + longint'(sh[smode-1][row][1]) * b +
        longint'(sh[smode-1][row][2]) * c + (longint'(sh[smode-1][row][3]) * 8192);
    q = (s + 4096) >>> 13;
    if (q < 0) return 0;
    if (q > 4095) return 4095;
    return int'(q);
  endfunction

  task automatic check(string tag, bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit we, logic [3:0] a, logic [31:0] d, bit pv,
                      int r, int g, int b, string tag);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    in_valid = pv; in_c0 = 12'(r); in_c1 = 12'(g); in_c2 = 12'(b);
    if (pv) begin
      q_exp.push_back({12'(model(0, r, g, b)), 12'(model(1, r, g, b)), 12'(model(2, r, g, b))});
      q_cyc.push_back(cyc + 3);
      q_tag.push_back(tag);
    end
    if (we) begin
      if (a == 4'hF) smode = int'(d[1:0]);
      else if (a[2:0] < 3'd6) begin
        sh[a[3]][a[2:1]][{a[0], 1'b0}] = d[15:0];
        sh[a[3]][a[2:1]][{a[0], 1'b1}] = d[31:16];
      end
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(1'b1, a, d, 1'b0, 0, 0, 0, "");
  endtask

  task automatic px(int r, int g, int b, string tag);
    step(1'b0, 4'h0, 32'h0, 1'b1, r, g, b, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 32'h0, 1'b0, 0, 0, 0, "");
  endtask

  task automatic load_bank(int bk, logic [15:0] m [12]);
    for (int p = 0; p < 6; p++) wr(4'(bk * 8 + p), {m[2*p+1], m[2*p]});
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_exp.size() == 0) begin
        check("R10", 1'b0, "unexpected out_valid", 1, 0);
      end else begin
        logic [35:0] e;
        int ec;
        string t;
        e = q_exp.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
        check(t, {out_red, out_green, out_blue} == e, "pixel",
              {out_red, out_green, out_blue}, e);
        check("R10", ec == cyc, "latency cycle", cyc, ec);
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired, run hung");
    summary();
  end

  initial begin
    logic [15:0] m [12];
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 4; c++) sh[b][r][c] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1", out_valid == 1'b0, "out_valid after reset", out_valid, 0);
    end
    px(100, 2000, 4095, "R1");
    // R2: bypass, back to back
    px(0, 0, 0, "R2");
    px(4095, 1, 2048, "R2");
    px(17, 3000, 999, "R2");
    // R12: unmapped writes do nothing (bank A all zero: mode 1 would give 0)
    wr(4'd6, 32'h2000_2000);
    wr(4'd7, 32'h2000_2000);
    wr(4'd14, 32'h2000_2000);
    wr(4'hF, 32'h1);           // mode 1, bank A still zero
    px(1000, 1000, 1000, "R12");
    // R6: identity in bank A
    m = '{16'h2000, 0, 0, 0, 0, 16'h2000, 0, 0, 0, 0, 16'h2000, 0};
    load_bank(0, m);
    px(1234, 567, 4095, "R6");
    px(0, 4095, 1, "R6");
    // R4 R7: cross terms, negatives and offsets
    m = '{16'h1800, 16'h0400, 16'hF800, 16'h0040,
          16'hE991, 16'h2000, 16'h0C00, 16'hFF00,
          16'h0A00, 16'hF600, 16'h2800, 16'h0010};
    load_bank(0, m);
    px(2000, 1000, 500, "R4");
    px(3000, 100, 4000, "R7");
    px(10, 20, 30, "R7");
    // R5 R3: bank B channel swap, mode 2
    m = '{0, 0, 16'h2000, 0,  0, 16'h2000, 0, 16'h0005,  16'h2000, 0, 0, 0};
    load_bank(1, m);
    wr(4'hF, 32'h2);
    px(111, 222, 333, "R5");
    px(4000, 5, 60, "R3");
    wr(4'hF, 32'h3);
    px(4000, 5, 60, "R3");
    wr(4'hF, 32'h1);
    px(4000, 5, 60, "R3");
    // R8: rounding
    m = '{16'h1000, 0, 0, 0,  16'hF000, 0, 0, 16'h0001,  16'h0800, 0, 0, 0};
    load_bank(0, m);
    px(1, 0, 0, "R8");
    px(3, 0, 0, "R8");
    px(5, 0, 0, "R8");
    // R9: clamping
    m = '{16'h4000, 0, 0, 0,  16'h2000, 0, 0, 16'hEC78,  16'h2000, 16'h2000, 16'h2000, 0};
    load_bank(0, m);
    px(4000, 100, 10, "R9");
    px(2047, 4095, 4095, "R9");
    px(2048, 0, 1365, "R9");
    // R11: write in the same cycle as a pixel
    step(1'b1, 4'd0, 32'h0000_2000, 1'b1, 3000, 0, 0, "R11");
    px(3000, 0, 0, "R11");
    step(1'b1, 4'hF, 32'h0, 1'b1, 3000, 0, 0, "R11");
    px(3000, 7, 9, "R11");
    // R10: bubbles
    wr(4'hF, 32'h2);
    px(1, 2, 3, "R10");
    idle(1);
    px(4, 5, 6, "R10");
    idle(2);
    px(7, 8, 9, "R10");
    px(10, 11, 12, "R10");
    idle(1);
    for (int i = 0; i < 60 && q_exp.size() != 0; i++) @(negedge clk);
    idle(4);
    check("R10", q_exp.size() == 0, "missing outputs", q_exp.size(), 0);
    summary();
  end
endmodule